// File: doc/BRIEF.md
# Five-Level Prioritized Interrupt Arbiter

This block sits beside a CPU core's sequencer. It collapses five interrupt request lines into at most one accepted request per instruction boundary. The lines have a fixed rank. The top line cannot be masked or disabled. The next three lines are restart levels: each can be masked individually, and each has a fixed service vector. The lowest line expects its vector to come from the requesting device. The second line is captured on its rising edge into a pending latch. The other lines are sampled as levels.

The core pulses `instrDone` when an instruction retires. A request is taken only on such a cycle, and only while the bus is not handed over to another master (`busHold` low). On acceptance the block raises `ackPulse` for one cycle. It also presents the winning level, its vector and a flag that says the vector must come from outside. These three outputs keep their values until the next acceptance. Every acceptance clears the global enable. Software sets and clears the enable with one-cycle strobes. All inputs are taken as synchronous to `clk`.

Top module: `irq_prio_arbiter`

## Requirements
- R1: While `rstN` is low and after its release, `ackPulse`, `ackLevel`, `ackVector`, `ackExtVec` and `intEnabled` are all 0.
- R2: A request is accepted only at a clock edge where `instrDone` is 1. `ackPulse` is high for exactly the one cycle after that edge.
- R3: No line, including the top line, is accepted at an edge where `busHold` is 1. Such an edge leaves `intEnabled` unchanged.
- R4: The rank runs from level 0 (`irqTop`, highest) through 1 (`irqEdge`), 2 (`irqMid`) and 3 (`irqLow`) to 4 (`irqExt`, lowest). When several lines are eligible, only the highest is acknowledged. The others stay pending for a later boundary.
- R5: Levels 1 to 4 are accepted only while `intEnabled` is 1. Level 0 ignores `intEnabled` and `maskIn`.
- R6: `maskIn[0]`, `maskIn[1]` and `maskIn[2]` block levels 1, 2 and 3 respectively when set to 1. Level 4 has no mask bit.
- R7: An acceptance clears `intEnabled` at the same edge, and this takes priority over both strobes. Otherwise `enClr` clears the enable and takes priority over `enSet`, which sets it. A set strobe in the same cycle as `instrDone` does not enable that boundary.
- R8: A rising edge on `irqEdge` sets a pending latch, whatever the mask and the enable. The latch holds after the line falls. It is cleared only when level 1 is acknowledged. A line held high does not set it again. A rising edge in the same cycle as the level-1 acknowledge leaves the latch set.
- R9: Levels 0, 2, 3 and 4 have no memory. A line that drops before a boundary is not accepted.
- R10: `ackLevel` carries the level index 0 to 4. For levels 0 to 3, `ackVector` is 0x0020 + 8 × level and `ackExtVec` is 0. For level 4, `ackVector` is 0 and `ackExtVec` is 1. All three keep their values between acceptances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqTop | input | 1 | Level 0 request, non-maskable, level-sensitive |
| irqEdge | input | 1 | Level 1 request, rising-edge captured |
| irqMid | input | 1 | Level 2 request, level-sensitive |
| irqLow | input | 1 | Level 3 request, level-sensitive |
| irqExt | input | 1 | Level 4 request, externally vectored |
| maskIn | input | 3 | Per-level mask for levels 1..3 (1 = blocked) |
| instrDone | input | 1 | Instruction boundary strobe |
| busHold | input | 1 | Bus granted to another master |
| enSet | input | 1 | Global enable set strobe |
| enClr | input | 1 | Global enable clear strobe |
| intEnabled | output | 1 | Global enable state |
| ackPulse | output | 1 | One-cycle acknowledge |
| ackLevel | output | 3 | Level of the last accepted request |
| ackVector | output | 16 | Fixed vector of the last accepted request |
| ackExtVec | output | 1 | Last accepted vector is supplied externally |

## Verification
Two kinds of collision can land on the same edge.

The first is an acceptance and an enable strobe. The bench drives `enSet` together with `instrDone`, once while the enable is clear and once while it is set. It expects no acceptance in the first case. In the second case it expects an acceptance followed by a cleared enable.

The second is a level-1 acknowledge and a fresh rising edge on `irqEdge`. The bench first leaves the latch pending with the line low. It then raises the line in the boundary cycle. It judges the result by a second level-1 acknowledge at the next enabled boundary, with no new edge in between.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int unsigned LVL_COUNT = 5;
  localparam int unsigned LVL_W     = $clog2(LVL_COUNT);
  localparam int unsigned MASK_W    = LVL_COUNT - 2;
  localparam int unsigned EDGE_IDX  = 1;

  typedef enum logic [LVL_W-1:0] {
    LVL_TOP = 0,
    LVL_EDGE = 1,
    LVL_MID = 2,
    LVL_LOW = 3,
    LVL_EXT = 4
  } lvl_e;

  // strobes from control to datapath for one boundary decision
  typedef struct packed {
    logic                 take;
    logic [LVL_COUNT-1:0] grantOh;
    logic [LVL_W-1:0]     lvl;
  } ctrl_strb_t;
endpackage

// File: rtl/irq_capture.sv
module irq_capture
  import irq_arb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [LVL_COUNT-1:0] reqLines,
  input  logic [MASK_W-1:0]    maskIn,
  input  logic                 intEnabled,
  input  logic                 clrEdge,
  output logic [LVL_COUNT-1:0] eligible
);
  logic edgePrev;
  logic edgePend;
  logic edgeRise;

  assign edgeRise = reqLines[EDGE_IDX] & ~edgePrev;

  // a new rise outranks the clear so a request in the ack cycle survives
  always_ff @(posedge clk) begin
    if (!rstN) begin
      edgePrev <= 1'b0;
      edgePend <= 1'b0;
    end else begin
      edgePrev <= reqLines[EDGE_IDX];
      edgePend <= (edgePend & ~clrEdge) | edgeRise;
    end
  end

  for (genvar i = 0; i < LVL_COUNT; i++) begin : g_elig
    if (i == 0) begin : g_top
      assign eligible[i] = reqLines[i];
    end else if (i == EDGE_IDX) begin : g_edge
      assign eligible[i] = edgePend & ~maskIn[i-1] & intEnabled;
    end else if (i <= MASK_W) begin : g_masked
      assign eligible[i] = reqLines[i] & ~maskIn[i-1] & intEnabled;
    end else begin : g_plain
      assign eligible[i] = reqLines[i] & intEnabled;
    end
  end

  // R8: a level-1 grant must consume a latched request
  a_r8_grant_needs_pend: assert property (@(posedge clk) disable iff (!rstN)
    clrEdge |-> edgePend);
  // R8: a rising input always leaves the latch set
  a_r8_rise_latches: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqLines[EDGE_IDX]) |=> edgePend);
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_arb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [LVL_COUNT-1:0] eligible,
  input  logic                 instrDone,
  input  logic                 busHold,
  output ctrl_strb_t           strb
);
  logic                 anyElig;
  logic [LVL_COUNT-1:0] winOh;
  logic [LVL_W-1:0]     winLvl;

  // fixed priority: lowest index wins
  always_comb begin
    anyElig = 1'b0;
    winOh   = '0;
    winLvl  = '0;
    for (int i = 0; i < LVL_COUNT; i++) begin
      if (eligible[i] && !anyElig) begin
        anyElig  = 1'b1;
        winOh[i] = 1'b1;
        winLvl   = LVL_W'(i);
      end
    end
  end

  always_comb begin
    strb.take    = instrDone & ~busHold & anyElig;
    strb.grantOh = strb.take ? winOh : '0;
    strb.lvl     = winLvl;
  end

  // R4: at most one level granted per boundary
  a_r4_single_grant: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.grantOh));

  for (genvar i = 1; i < LVL_COUNT; i++) begin : g_rank_chk
    // R4: a grant never passes over a higher eligible level
    a_r4_no_bypass: assert property (@(posedge clk) disable iff (!rstN)
      strb.grantOh[i] |-> !(|eligible[i-1:0]));
  end
endmodule

// File: rtl/irq_result.sv
module irq_result
  import irq_arb_pkg::*;
#(
  parameter int unsigned VEC_W    = 16,
  parameter int unsigned VEC_BASE = 32'h0020,
  parameter int unsigned VEC_STEP = 32'h0008
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_strb_t       strb,
  input  logic             enSet,
  input  logic             enClr,
  output logic             intEnabled,
  output logic             ackPulse,
  output logic [LVL_W-1:0] ackLevel,
  output logic [VEC_W-1:0] ackVector,
  output logic             ackExtVec
);
  logic [VEC_W-1:0] vecTab [LVL_COUNT];
  logic [VEC_W-1:0] selVec;

  for (genvar i = 0; i < LVL_COUNT; i++) begin : g_vec
    if (i == LVL_COUNT - 1) begin : g_ext
      assign vecTab[i] = '0;
    end else begin : g_fixed
      assign vecTab[i] = VEC_W'(VEC_BASE + VEC_STEP * i);
    end
  end

  always_comb begin
    selVec = '0;
    for (int i = 0; i < LVL_COUNT; i++) begin
      if (strb.grantOh[i]) selVec = vecTab[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intEnabled <= 1'b0;
      ackPulse   <= 1'b0;
      ackLevel   <= '0;
      ackVector  <= '0;
      ackExtVec  <= 1'b0;
    end else begin
      if (strb.take)  intEnabled <= 1'b0;
      else if (enClr) intEnabled <= 1'b0;
      else if (enSet) intEnabled <= 1'b1;
      ackPulse <= strb.take;
      if (strb.take) begin
        ackLevel  <= strb.lvl;
        ackVector <= selVec;
        ackExtVec <= (strb.lvl == LVL_W'(LVL_COUNT - 1));
      end
    end
  end

  // R7: acceptance always leaves the enable cleared
  a_r7_take_clears: assert property (@(posedge clk) disable iff (!rstN)
    strb.take |=> !intEnabled);
  // R10: result fields hold between acceptances
  a_r10_result_held: assert property (@(posedge clk) disable iff (!rstN)
    !strb.take |=> ($stable(ackVector) && $stable(ackLevel) && $stable(ackExtVec)));
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
  import irq_arb_pkg::*;
#(
  parameter int unsigned VEC_W    = 16,
  parameter int unsigned VEC_BASE = 32'h0020,
  parameter int unsigned VEC_STEP = 32'h0008
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              irqTop,
  input  logic              irqEdge,
  input  logic              irqMid,
  input  logic              irqLow,
  input  logic              irqExt,
  input  logic [MASK_W-1:0] maskIn,
  input  logic              instrDone,
  input  logic              busHold,
  input  logic              enSet,
  input  logic              enClr,
  output logic              intEnabled,
  output logic              ackPulse,
  output logic [LVL_W-1:0]  ackLevel,
  output logic [VEC_W-1:0]  ackVector,
  output logic              ackExtVec
);
  logic [LVL_COUNT-1:0] reqLines;
  logic [LVL_COUNT-1:0] eligible;
  ctrl_strb_t           strb;

  assign reqLines = {irqExt, irqLow, irqMid, irqEdge, irqTop};

  irq_capture u_capture (
    .clk        (clk),
    .rstN       (rstN),
    .reqLines   (reqLines),
    .maskIn     (maskIn),
    .intEnabled (intEnabled),
    .clrEdge    (strb.grantOh[EDGE_IDX]),
    .eligible   (eligible)
  );

  irq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .eligible  (eligible),
    .instrDone (instrDone),
    .busHold   (busHold),
    .strb      (strb)
  );

  irq_result #(
    .VEC_W    (VEC_W),
    .VEC_BASE (VEC_BASE),
    .VEC_STEP (VEC_STEP)
  ) u_result (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .enSet      (enSet),
    .enClr      (enClr),
    .intEnabled (intEnabled),
    .ackPulse   (ackPulse),
    .ackLevel   (ackLevel),
    .ackVector  (ackVector),
    .ackExtVec  (ackExtVec)
  );

  // R2: acknowledge only after a boundary edge
  a_r2_boundary_only: assert property (@(posedge clk) disable iff (!rstN)
    ackPulse |-> $past(instrDone));
  // R3: no acknowledge out of a held-bus edge
  a_r3_hold_blocks: assert property (@(posedge clk) disable iff (!rstN)
    ackPulse |-> !$past(busHold));
  // R5: maskable levels need the enable at acceptance
  a_r5_enable_gate: assert property (@(posedge clk) disable iff (!rstN)
    (ackPulse && ackLevel != '0) |-> $past(intEnabled));
  // R7: enable is down while the acknowledge is shown
  a_r7_disabled_on_ack: assert property (@(posedge clk) disable iff (!rstN)
    ackPulse |-> !intEnabled);
  // R10: level index stays in range
  a_r10_level_range: assert property (@(posedge clk) disable iff (!rstN)
    ackPulse |-> (ackLevel < LVL_W'(LVL_COUNT)));
endmodule

// File: tb/test_irq_prio_arbiter.sv
module test_irq_prio_arbiter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        irqTop = 0, irqEdge = 0, irqMid = 0, irqLow = 0, irqExt = 0;
  logic [2:0]  maskIn = '0;
  logic        instrDone = 0, busHold = 0, enSet = 0, enClr = 0;
  logic        intEnabled, ackPulse, ackExtVec;
  logic [2:0]  ackLevel;
  logic [15:0] ackVector;
  int          nChk = 0;
  int          nBad = 0;
  bit          finished = 0;

  always #4 clk = ~clk;

  irq_prio_arbiter i_irq_prio_arbiter (
    .clk(clk), .rstN(rstN), .irqTop(irqTop), .irqEdge(irqEdge), .irqMid(irqMid),
    .irqLow(irqLow), .irqExt(irqExt), .maskIn(maskIn), .instrDone(instrDone),
    .busHold(busHold), .enSet(enSet), .enClr(enClr), .intEnabled(intEnabled),
    .ackPulse(ackPulse), .ackLevel(ackLevel), .ackVector(ackVector), .ackExtVec(ackExtVec)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic bound();
    instrDone = 1; @(negedge clk); instrDone = 0;
  endtask

  task automatic enOn();
    enSet = 1; @(negedge clk); enSet = 0;
  endtask

  task automatic expAck(input string req, input int lvl, input int vec, input int ext);
    chk(req, "ackPulse", ackPulse, 1);
    chk(req, "ackLevel", ackLevel, lvl);
    chk(req, "ackVector", ackVector, vec);
    chk(req, "ackExtVec", ackExtVec, ext);
    chk(req, "intEnabled after ack", intEnabled, 0);
  endtask

  task automatic t_reset();
    chk("R1", "ackPulse", ackPulse, 0);
    chk("R1", "ackLevel", ackLevel, 0);
    chk("R1", "ackVector", ackVector, 0);
    chk("R1", "ackExtVec", ackExtVec, 0);
    chk("R1", "intEnabled", intEnabled, 0);
  endtask

  task automatic t_boundary();
    enOn(); irqLow = 1; step(3);
    chk("R2", "no ack without boundary", ackPulse, 0);
    bound(); expAck("R2", 3, 16'h0038, 0);
    step(1); chk("R2", "pulse one cycle", ackPulse, 0);
    irqLow = 0;
  endtask

  task automatic t_hold();
    enOn(); irqTop = 1; busHold = 1; bound();
    chk("R3", "no ack under hold", ackPulse, 0);
    chk("R3", "enable kept under hold", intEnabled, 1);
    busHold = 0; bound(); expAck("R3", 0, 16'h0020, 0);
    irqTop = 0; step(1);
  endtask

  task automatic t_priority();
    enOn(); irqMid = 1; irqLow = 1; irqExt = 1; bound();
    expAck("R4", 2, 16'h0030, 0);
    irqMid = 0; enOn(); bound(); expAck("R4", 3, 16'h0038, 0);
    irqLow = 0; enOn(); bound(); expAck("R10", 4, 16'h0000, 1);
    irqExt = 0; step(3);
    chk("R10", "level held", ackLevel, 4);
    chk("R10", "extvec held", ackExtVec, 1);
    // top beats a pending edge, which survives
    irqEdge = 1; step(1); irqEdge = 0; irqTop = 1; enOn(); bound();
    expAck("R4", 0, 16'h0020, 0);
    irqTop = 0; enOn(); bound(); expAck("R4", 1, 16'h0028, 0);
  endtask

  task automatic t_disabled();
    irqExt = 1; bound();
    chk("R5", "no ack when disabled", ackPulse, 0);
    irqTop = 1; maskIn = 3'b111; bound();
    expAck("R5", 0, 16'h0020, 0);
    irqTop = 0; maskIn = 3'b000;
    // set strobe in the boundary cycle does not enable that boundary
    enSet = 1; instrDone = 1; @(negedge clk); enSet = 0; instrDone = 0;
    chk("R7", "no ack on set+boundary", ackPulse, 0);
    chk("R7", "set took effect", intEnabled, 1);
    bound(); expAck("R7", 4, 16'h0000, 1);
    enOn(); enSet = 1; instrDone = 1; @(negedge clk); enSet = 0; instrDone = 0;
    chk("R7", "ack wins over set", ackPulse, 1);
    chk("R7", "clear wins over set", intEnabled, 0);
    irqExt = 0;
    enOn(); enClr = 1; @(negedge clk); enClr = 0;
    chk("R7", "clear strobe", intEnabled, 0);
    enSet = 1; enClr = 1; @(negedge clk); enSet = 0; enClr = 0;
    chk("R7", "clear beats set", intEnabled, 0);
  endtask

  task automatic t_mask();
    enOn(); maskIn = 3'b100; irqLow = 1; bound();
    chk("R6", "masked level3 ignored", ackPulse, 0);
    chk("R6", "enable kept", intEnabled, 1);
    maskIn = 3'b010; irqMid = 1; bound();
    expAck("R6", 3, 16'h0038, 0);
    irqMid = 0; irqLow = 0; maskIn = 3'b111; irqExt = 1; enOn(); bound();
    expAck("R6", 4, 16'h0000, 1);
    irqExt = 0; maskIn = 3'b000;
  endtask

  task automatic t_level_drop();
    enOn(); irqMid = 1; step(2); irqMid = 0; bound();
    chk("R9", "dropped level not taken", ackPulse, 0);
    chk("R9", "enable kept", intEnabled, 1);
    enClr = 1; @(negedge clk); enClr = 0;
  endtask

  task automatic t_edge();
    maskIn = 3'b001; irqEdge = 1; step(1); irqEdge = 0; step(2);
    enOn(); bound();
    chk("R8", "masked edge not taken", ackPulse, 0);
    maskIn = 3'b000; bound();
    expAck("R8", 1, 16'h0028, 0);
    enOn(); bound();
    chk("R8", "latch cleared by ack", ackPulse, 0);
    irqEdge = 1; step(1); bound();
    expAck("R8", 1, 16'h0028, 0);
    enOn(); bound();
    chk("R8", "held high no retrigger", ackPulse, 0);
    irqEdge = 0; step(1);
    // collision: pending latch plus a new rise in the ack cycle
    irqEdge = 1; step(1); irqEdge = 0; step(1);
    irqEdge = 1; instrDone = 1; @(negedge clk); instrDone = 0;
    expAck("R8", 1, 16'h0028, 0);
    enOn(); bound();
    expAck("R8", 1, 16'h0028, 0);
    irqEdge = 0; enClr = 1; @(negedge clk); enClr = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nBad++;
      $display("FAIL R2 watchdog actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    step(3);
    t_reset();
    rstN = 1;
    step(1);
    t_reset();
    t_boundary();
    t_hold();
    t_priority();
    t_disabled();
    t_mask();
    t_level_drop();
    t_edge();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule